// File: doc/BRIEF.md
# Zero-Run Stream Expander

This block restores a byte stream in which runs of the value 0x00 have been shortened. Bytes other than zero pass through unchanged. A zero in the input stands for the start of a zero run, and the byte that follows it gives the total length of that run, counting the zero itself. The expander removes the length byte from the stream and sends out the full number of zeros.

Both sides are byte-wide valid/ready streams. An end-of-stream marker travels with the final input byte. The expander moves that marker to the final byte it produces, including any zeros it inserts. The output side has one register stage, so a byte stays stable while the consumer holds ready low. While inserted zeros are being sent, the input is held off. A stream that ends on a zero with no length byte after it is flagged as truncated.

Top module: `zrun_expander`

## Requirements
- R1: Every input byte with a value other than 0x00 appears once on the output with the same value and in the same order as it arrived.
- R2: The input byte that follows a zero, which is the run length L, never appears on the output as data.
- R3: A run length L from 2 to 255 produces exactly L output zeros in total for that run.
- R4: A run length of 1 or 0 produces exactly one output zero, and no extra zeros are inserted.
- R5: After a run length L of 2 or more is accepted, and with the consumer always ready, inReady stays low for exactly L-1 cycles before the next input byte can be taken.
- R6: outLast is high only on the final output byte of a stream. That byte is the last zero of the run when the length byte carried the end-of-stream marker.
- R7: A zero that carries inLast (bit on the input) with no length byte after it produces one zero with outLast high and sets truncFlag. truncFlag clears when the next input byte is accepted.
- R8: While outValid is high and outReady is low, outData and outLast hold and no byte is lost. inReady is low while the output register is full and stalled.
- R9: After reset, outValid is 0, truncFlag is 0 and inReady is 1.
- R10: Runs longer than 255 arrive as back-to-back zero/length pairs, and their zero counts add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | DATA_W | Compressed input byte |
| inValid | input | 1 | Input byte present |
| inLast | input | 1 | Input byte ends the stream |
| inReady | output | 1 | Expander accepts an input byte this cycle |
| outData | output | DATA_W | Expanded output byte |
| outValid | output | 1 | Output byte present |
| outLast | output | 1 | Output byte ends the stream |
| outReady | input | 1 | Consumer accepts the output byte |
| truncFlag | output | 1 | Last stream ended on a zero without a length byte |

## Verification
The assertions check several properties on every cycle:
- A stalled output byte holds its value.
- The input is held off right after a long run length is accepted.
- The fill counter is never zero while zeros are still being inserted.
- Loading an end-of-stream byte returns the control to its idle state.
- A raised truncation flag coincides with a zero that carries the end marker.

Only the bench's scenarios show the following:
- The exact number of zeros for each of the 256 length values.
- Pass-through of all non-zero values.
- The placement of the end marker after a run.
- Lossless transfer under irregular consumer backpressure.

// File: rtl/zrun_pkg.sv
package zrun_pkg;
  typedef enum logic [1:0] {
    ST_DATA  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FILL  = 2'd2
  } zrunState_e;

  typedef struct packed {
    logic loadEn;    // write a byte into the output register
    logic loadZero;  // byte written is zero rather than the input byte
    logic loadLast;  // byte written ends the stream
    logic setTrunc;  // stream ended on a bare zero
    logic clrTrunc;  // a new input byte was accepted
  } zrunStrobe_t;
endpackage

// File: rtl/zrun_ctrl.sv
module zrun_ctrl
  import zrun_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              outFree,
  output logic              inReady,
  output zrunStrobe_t       strobe
);
  localparam int CNT_W = DATA_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  zrunState_e       state, stateNext;
  logic [CNT_W-1:0] remCnt, remNext;
  logic             pendLast, pendNext;
  logic             accept, isZero;

  assign inReady = (state != ST_FILL) && outFree;
  assign accept  = inValid && inReady;
  assign isZero  = (inData == '0);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    remNext   = remCnt;
    pendNext  = pendLast;
    case (state)
      ST_DATA: begin
        if (accept) begin
          strobe.clrTrunc = 1'b1;
          if (!isZero) begin
            strobe.loadEn   = 1'b1;
            strobe.loadLast = inLast;
          end else if (inLast) begin
            strobe.loadEn   = 1'b1;
            strobe.loadZero = 1'b1;
            strobe.loadLast = 1'b1;
            strobe.setTrunc = 1'b1;
          end else begin
            stateNext = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (accept) begin
          strobe.loadEn   = 1'b1;
          strobe.loadZero = 1'b1;
          if (inData <= ONE) begin
            strobe.loadLast = inLast;
            stateNext       = ST_DATA;
          end else begin
            remNext   = inData - ONE;
            pendNext  = inLast;
            stateNext = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (outFree) begin
          strobe.loadEn   = 1'b1;
          strobe.loadZero = 1'b1;
          strobe.loadLast = pendLast && (remCnt == ONE);
          remNext         = remCnt - ONE;
          if (remCnt == ONE) stateNext = ST_DATA;
        end
      end
      default: stateNext = ST_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_DATA;
      remCnt   <= '0;
      pendLast <= 1'b0;
    end else begin
      state    <= stateNext;
      remCnt   <= remNext;
      pendLast <= pendNext;
    end
  end

  // R5: a long run length blocks the input on the following cycle
  assert_hold_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT && accept && inData > ONE) |=> !inReady);

  // R3: the fill counter is live whenever zeros are still owed
  assert_fill_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |-> (remCnt != '0));

  // R6: after an end-of-stream byte is loaded, nothing is left pending
  assert_last_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && strobe.loadLast) |=> (state == ST_DATA));
endmodule

// File: rtl/zrun_datapath.sv
module zrun_datapath
  import zrun_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  zrunStrobe_t       strobe,
  input  logic              outReady,
  output logic              outFree,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              truncFlag
);
  logic [DATA_W-1:0] loadByte;

  assign outFree  = !outValid || outReady;
  assign loadByte = strobe.loadZero ? '0 : inData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outValid  <= 1'b0;
      outLast   <= 1'b0;
      truncFlag <= 1'b0;
    end else begin
      if (strobe.loadEn) begin
        outData  <= loadByte;
        outLast  <= strobe.loadLast;
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (strobe.setTrunc)      truncFlag <= 1'b1;
      else if (strobe.clrTrunc) truncFlag <= 1'b0;
    end
  end

  // R8: a stalled output byte is held unchanged
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R7: truncation is raised only together with a terminal zero
  assert_trunc_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(truncFlag) |-> (outValid && outLast && outData == '0));
endmodule

// File: rtl/zrun_expander.sv
module zrun_expander
  import zrun_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady,
  output logic              truncFlag
);
  zrunStrobe_t strobe;
  logic        outFree;

  zrun_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .inValid (inValid),
    .inLast  (inLast),
    .outFree (outFree),
    .inReady (inReady),
    .strobe  (strobe)
  );

  zrun_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .strobe    (strobe),
    .outReady  (outReady),
    .outFree   (outFree),
    .outData   (outData),
    .outValid  (outValid),
    .outLast   (outLast),
    .truncFlag (truncFlag)
  );

  // R9: nothing is presented on the output in the cycle after reset
  assert_reset_idle_R9: assert property (@(posedge clk)
    !rstN |=> (!outValid && !truncFlag));
endmodule

// File: tb/zrun_expander_tb_top.sv
module zrun_expander_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid, outLast, truncFlag;
  logic       outReady = 1'b0;

  always #2 clk = ~clk;

  zrun_expander dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outLast(outLast),
    .outReady(outReady), .truncFlag(truncFlag)
  );

  int         total = 0;
  int         bad = 0;
  int         readyMode = 0;   // 0 always ready, 1 irregular, 2 stalled
  string      curReq = "R1";
  logic [8:0] expQ[$];         // {last, byte}
  logic [8:0] stim[$];         // {last, byte}
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // consumer: choose ready at the falling edge, record the byte that the next rising edge takes
  always @(negedge clk) begin
    logic nr;
    logic [8:0] e;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rstN)               nr = 1'b0;
    else if (readyMode == 0) nr = 1'b1;
    else if (readyMode == 1) nr = lfsr[0] | lfsr[3];
    else                     nr = 1'b0;
    outReady = nr;
    if (outValid && nr) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected output byte", int'(outData), -1);
      end else begin
        e = expQ.pop_front();
        check(outData == e[7:0], curReq, "output byte", int'(outData), int'(e[7:0]));
        check(outLast == e[8], curReq, "output last", int'(outLast), int'(e[8]));
      end
    end
  end

  // reference expansion computed from the requirements; returns the expected truncation flag
  function automatic bit buildExpect();
    int i = 0;
    bit tr = 1'b0;
    while (i < stim.size()) begin
      logic [8:0] b = stim[i];
      if (b[7:0] != 8'h00) begin
        expQ.push_back(b);
        tr = 1'b0;
        i++;
      end else if (b[8]) begin
        expQ.push_back(9'h100);
        tr = 1'b1;
        i++;
      end else begin
        logic [8:0] c = stim[i+1];
        int n = (c[7:0] <= 8'd1) ? 1 : int'(c[7:0]);
        for (int k = 0; k < n; k++) expQ.push_back({(c[8] && k == n-1), 8'h00});
        tr = 1'b0;
        i += 2;
      end
    end
    return tr;
  endfunction

  task automatic sendByte(input logic [8:0] v, output int waited);
    @(negedge clk);
    inValid = 1'b1;
    inData  = v[7:0];
    inLast  = v[8];
    waited  = 0;
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
      waited++;
    end
    @(posedge clk);
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || outValid) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    #1;
    check(expQ.size() == 0, curReq, "bytes still expected after drain", expQ.size(), 0);
  endtask

  task automatic runStream();
    bit exT;
    int w;
    exT = buildExpect();
    foreach (stim[i]) sendByte(stim[i], w);
    idleIn();
    drain();
    check(truncFlag == exT, "R7", "truncFlag after stream", int'(truncFlag), int'(exT));
    stim.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    logic [15:0] g;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    check(outValid == 1'b0, "R9", "outValid after reset", int'(outValid), 0);
    check(truncFlag == 1'b0, "R9", "truncFlag after reset", int'(truncFlag), 0);
    check(inReady == 1'b1, "R9", "inReady after reset", int'(inReady), 1);

    // R1: all non-zero values pass through
    curReq = "R1";
    for (int v = 1; v < 256; v++) stim.push_back({(v == 255), 8'(v)});
    runStream();

    // R2 R3 R4: every run length, each followed by a marker literal
    curReq = "R2 R3 R4";
    for (int l = 0; l < 256; l++) begin
      stim.push_back({1'b0, 8'h00});
      stim.push_back({1'b0, 8'(l)});
      stim.push_back({(l == 255), 8'h5A});
    end
    runStream();

    // R6: end marker carried on a length byte
    curReq = "R6";
    stim.push_back({1'b0, 8'h21});
    stim.push_back({1'b0, 8'h00});
    stim.push_back({1'b1, 8'd4});
    runStream();
    stim.push_back({1'b0, 8'h00});
    stim.push_back({1'b1, 8'd1});
    runStream();

    // R10: long run split into pairs, 255 + 255 + 45 zeros
    curReq = "R10";
    for (int k = 0; k < 2; k++) begin
      stim.push_back({1'b0, 8'h00});
      stim.push_back({1'b0, 8'd255});
    end
    stim.push_back({1'b0, 8'h00});
    stim.push_back({1'b0, 8'd45});
    stim.push_back({1'b1, 8'h07});
    runStream();

    // R5: input held off for L-1 cycles after a length byte
    curReq = "R5";
    foreach (stim[i]) ;
    for (int l = 0; l < 8; l++) begin
      stim.push_back({1'b0, 8'h11});
      stim.push_back({1'b0, 8'h00});
      stim.push_back({1'b0, 8'(l)});
      stim.push_back({1'b1, 8'h22});
      void'(buildExpect());
      for (int i = 0; i < 3; i++) sendByte(stim[i], w);
      sendByte(stim[3], w);
      check(w == ((l > 1) ? l - 1 : 0), "R5", "cycles with input held off", w, (l > 1) ? l - 1 : 0);
      idleIn();
      drain();
      stim.delete();
    end

    // R7: truncated stream, then cleared by the next byte
    curReq = "R7";
    stim.push_back({1'b0, 8'h44});
    stim.push_back({1'b1, 8'h00});
    runStream();
    stim.push_back({1'b1, 8'h55});
    runStream();

    // R8: stalled consumer holds the byte and blocks the input
    curReq = "R8";
    readyMode = 2;
    stim.push_back({1'b1, 8'h33});
    void'(buildExpect());
    sendByte(stim[0], w);
    idleIn();
    repeat (5) @(negedge clk);
    #1;
    check(outValid == 1'b1, "R8", "outValid while stalled", int'(outValid), 1);
    check(outData == 8'h33, "R8", "outData while stalled", int'(outData), 8'h33);
    check(inReady == 1'b0, "R8", "inReady while stalled", int'(inReady), 0);
    readyMode = 0;
    drain();
    stim.delete();

    // R8 R1 R3: mixed stream under irregular backpressure
    curReq = "R8 R1 R3";
    readyMode = 1;
    g = 16'h1D2B;
    for (int k = 0; k < 500; k++) begin
      g = {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
      if (g[2:0] == 3'd0 || g[7:0] == 8'h00) begin
        stim.push_back({1'b0, 8'h00});
        stim.push_back({(k == 499), 8'(g[15:8] & 8'h1F)});
      end else begin
        stim.push_back({(k == 499), g[7:0]});
      end
    end
    runStream();
    readyMode = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule